// File: doc/BRIEF.md
# Two-Plane Programmable Logic Array

This block evaluates a set of sum-of-products functions whose structure is held in registers. There are N_IN inputs, N_TERM product terms and N_OUT outputs. Every product term ANDs a chosen set of input literals. Every output ORs the product terms routed to it. The literal choice and the routing are both programmable, and one term may feed any number of outputs.

The personality is loaded one product-term row per clock through a synchronous write port. A combinational readback port returns any stored row. The evaluation path from `in_vec` to `out_vec` has no register in it.

A stored row is `N_IN*2 + N_OUT` bits wide and is laid out as follows:

- bits `[N_IN-1:0]` hold the polarity bits.
- bits `[2*N_IN-1:N_IN]` hold the care bits.
- bits `[2*N_IN+N_OUT-1:2*N_IN]` hold the output mask.

Input i of `in_vec` maps to bit i of the polarity field and bit i of the care field. Output m maps to mask bit m.

The number of terms must be below 2^N_IN. A set of functions that needs more distinct terms than N_TERM cannot be mapped.

Top module: `pla_array`

## Requirements
- R1: While `rst_n` is low and after its release, before any write, every row reads back as 0 and `out_vec` is 0 for every input value.
- R2: When `cfg_we` is 1 at a rising edge of `clk` and `cfg_row` < N_TERM, row `cfg_row` takes `cfg_data`. The new value appears on `rd_data` when `rd_row` selects that row, and it governs `out_vec` from just after that edge. Before that edge the old row still applies.
- R3: In the slot for input i, care=1 with polarity=1 requires `in_vec[i]`=1. Care=1 with polarity=0 requires `in_vec[i]`=0. Care=0 removes input i from the term.
- R4: A term whose care bits are all 0 is always true.
- R5: `out_vec[m]` is the OR of all terms whose mask bit m is 1. An output with no connected term drives 0.
- R6: A single term whose mask has several bits set drives all of those outputs at once.
- R7: A write with `cfg_row` >= N_TERM changes no row and no output. A readback with `rd_row` >= N_TERM returns 0.
- R8: `out_vec` follows a change of `in_vec` within the same clock cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset, clears all rows |
| cfg_we | input | 1 | Row write strobe |
| cfg_row | input | ROW_AW | Index of the row to write |
| cfg_data | input | ROW_W | Row payload: mask, care, polarity |
| rd_row | input | ROW_AW | Index of the row to read back |
| rd_data | output | ROW_W | Stored content of the selected row, 0 when out of range |
| in_vec | input | N_IN | Logic inputs |
| out_vec | output | N_OUT | Logic outputs |

## Verification
Two results are due at different times.

- **Readback and writes:** a written row becomes visible on `rd_data` and on `out_vec` just after the rising edge that accepted the write. The bench drives each write at a falling edge and samples one step after the next falling edge. It also samples once before the accepting edge, to confirm that the old personality still holds then.
- **Combinational evaluation:** `out_vec` is due in the same cycle as an input change. The bench changes `in_vec` away from any edge and samples one time step later, with no rising edge in between.

Expected outputs come from a bench-side shadow of the rows and from the four written-out reference equations.

// File: rtl/pla_pkg.sv
package pla_pkg;

   // Address width for a count of rows, never below one bit.
   function automatic int addr_bits(input int count);
      int w;
      w = 1;
      while ((1 << w) < count) w++;
      return w;
   endfunction

   // Row payload width for a given shape.
   function automatic int row_bits(input int n_in, input int n_out);
      return 2 * n_in + n_out;
   endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
   parameter int N_IN   = 3,
   parameter int N_TERM = 5,
   parameter int N_OUT  = 4,
   parameter int ROW_AW = pla_pkg::addr_bits(N_TERM),
   parameter int ROW_W  = pla_pkg::row_bits(N_IN, N_OUT)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [ROW_AW-1:0]                 wr_row,
   input  logic [ROW_W-1:0]                  wr_data,
   input  logic [ROW_AW-1:0]                 rd_row,
   output logic [ROW_W-1:0]                  rd_data,
   output logic [N_TERM-1:0][N_IN-1:0]       care_q,
   output logic [N_TERM-1:0][N_IN-1:0]       pol_q,
   output logic [N_TERM-1:0][N_OUT-1:0]      mask_q
);

   localparam int POL_LSB  = 0;
   localparam int CARE_LSB = N_IN;
   localparam int MASK_LSB = 2 * N_IN;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         care_q <= '0;
         pol_q  <= '0;
         mask_q <= '0;
      end else if (wr_en) begin
         for (int p = 0; p < N_TERM; p++) begin
            if (wr_row == ROW_AW'(p)) begin
               pol_q[p]  <= wr_data[POL_LSB  +: N_IN];
               care_q[p] <= wr_data[CARE_LSB +: N_IN];
               mask_q[p] <= wr_data[MASK_LSB +: N_OUT];
            end
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int p = 0; p < N_TERM; p++) begin
         if (rd_row == ROW_AW'(p)) begin
            rd_data = {mask_q[p], care_q[p], pol_q[p]};
         end
      end
   end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
   parameter int N_IN   = 3,
   parameter int N_TERM = 5
) (
   input  logic [N_IN-1:0]                   in_vec,
   input  logic [N_TERM-1:0][N_IN-1:0]       care_q,
   input  logic [N_TERM-1:0][N_IN-1:0]       pol_q,
   output logic [N_TERM-1:0]                 term_vec
);

   for (genvar p = 0; p < N_TERM; p++) begin : g_term
      logic [N_IN-1:0] lit_ok;
      // A slot passes when it is not cared for, or the input matches its polarity.
      assign lit_ok      = ~care_q[p] | ~(in_vec ^ pol_q[p]);
      assign term_vec[p] = &lit_ok;
   end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
   parameter int N_TERM = 5,
   parameter int N_OUT  = 4
) (
   input  logic [N_TERM-1:0]                 term_vec,
   input  logic [N_TERM-1:0][N_OUT-1:0]      mask_q,
   output logic [N_OUT-1:0]                  out_vec
);

   for (genvar m = 0; m < N_OUT; m++) begin : g_out
      logic [N_TERM-1:0] column;
      for (genvar p = 0; p < N_TERM; p++) begin : g_col
         assign column[p] = mask_q[p][m];
      end
      assign out_vec[m] = |(column & term_vec);
   end

endmodule

// File: rtl/pla_array.sv
module pla_array #(
   parameter int N_IN   = 3,
   parameter int N_TERM = 5,
   parameter int N_OUT  = 4,
   parameter int ROW_AW = pla_pkg::addr_bits(N_TERM),
   parameter int ROW_W  = pla_pkg::row_bits(N_IN, N_OUT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ROW_AW-1:0] cfg_row,
   input  logic [ROW_W-1:0]  cfg_data,
   input  logic [ROW_AW-1:0] rd_row,
   output logic [ROW_W-1:0]  rd_data,
   input  logic [N_IN-1:0]   in_vec,
   output logic [N_OUT-1:0]  out_vec
);

   if (N_IN < 1 || N_TERM < 1 || N_OUT < 1) begin : g_bad_shape
      $error("pla_array: every dimension must be at least 1");
   end
   if (N_IN > 30 || N_TERM >= (1 << N_IN)) begin : g_bad_terms
      $error("pla_array: N_TERM must be below 2**N_IN");
   end
   if (ROW_AW != pla_pkg::addr_bits(N_TERM)) begin : g_bad_aw
      $error("pla_array: ROW_AW must match N_TERM");
   end
   if (ROW_W != pla_pkg::row_bits(N_IN, N_OUT)) begin : g_bad_w
      $error("pla_array: ROW_W must be 2*N_IN+N_OUT");
   end

   logic [N_TERM-1:0][N_IN-1:0]  care_q;
   logic [N_TERM-1:0][N_IN-1:0]  pol_q;
   logic [N_TERM-1:0][N_OUT-1:0] mask_q;
   logic [N_TERM-1:0]            term_vec;

   pla_cfg_store #(
      .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .ROW_AW(ROW_AW), .ROW_W(ROW_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we), .wr_row(cfg_row), .wr_data(cfg_data),
      .rd_row(rd_row), .rd_data(rd_data),
      .care_q(care_q), .pol_q(pol_q), .mask_q(mask_q)
   );

   pla_and_plane #(
      .N_IN(N_IN), .N_TERM(N_TERM)
   ) u_and (
      .in_vec(in_vec), .care_q(care_q), .pol_q(pol_q), .term_vec(term_vec)
   );

   pla_or_plane #(
      .N_TERM(N_TERM), .N_OUT(N_OUT)
   ) u_or (
      .term_vec(term_vec), .mask_q(mask_q), .out_vec(out_vec)
   );

endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
   parameter int N_IN   = 3,
   parameter int N_TERM = 5,
   parameter int N_OUT  = 4,
   parameter int ROW_AW = pla_pkg::addr_bits(N_TERM),
   parameter int ROW_W  = pla_pkg::row_bits(N_IN, N_OUT)
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          cfg_we,
   input logic [ROW_AW-1:0]             cfg_row,
   input logic [ROW_W-1:0]              cfg_data,
   input logic [ROW_AW-1:0]             rd_row,
   input logic [ROW_W-1:0]              rd_data,
   input logic [N_OUT-1:0]              out_vec,
   input logic [N_TERM-1:0][N_IN-1:0]   care_q,
   input logic [N_TERM-1:0][N_IN-1:0]   pol_q,
   input logic [N_TERM-1:0][N_OUT-1:0]  mask_q,
   input logic [N_TERM-1:0]             term_vec
);

   localparam logic [ROW_AW:0] ROW_LIM = (ROW_AW + 1)'(N_TERM);

   logic in_range;
   assign in_range = ({1'b0, cfg_row} < ROW_LIM);

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mask_q == '0 && care_q == '0 && pol_q == '0)); // R1

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && in_range) |=> (rd_row != $past(cfg_row)) || (rd_data == $past(cfg_data))); // R2

   AST_ROW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> (rd_row != $past(rd_row)) || (rd_data == $past(rd_data))); // R2

   AST_OUT_NEEDS_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vec != '0) |-> (term_vec != '0)); // R5

   AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !in_range) |=> ($stable(care_q) && $stable(pol_q) && $stable(mask_q))); // R7

   for (genvar p = 0; p < N_TERM; p++) begin : g_term_chk
      AST_EMPTY_TERM_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
         (care_q[p] == '0) |-> term_vec[p]); // R4
   end

endmodule

bind pla_array pla_array_chk #(
   .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .ROW_AW(ROW_AW), .ROW_W(ROW_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_data(cfg_data),
   .rd_row(rd_row), .rd_data(rd_data), .out_vec(out_vec),
   .care_q(care_q), .pol_q(pol_q), .mask_q(mask_q), .term_vec(term_vec)
);

// File: tb/pla_array_tb.sv
module pla_array_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NI = 3;
   localparam int NT = 5;
   localparam int NO = 4;
   localparam int AW = 3;
   localparam int RW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [AW-1:0] cfg_row = '0;
   logic [RW-1:0] cfg_data = '0;
   logic [AW-1:0] rd_row = '0;
   logic [RW-1:0] rd_data;
   logic [NI-1:0] in_vec = '0;
   logic [NO-1:0] out_vec;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [RW-1:0] shadow [NT];

   always #(CLK_PERIOD/2) clk = ~clk;

   pla_array #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_data(cfg_data),
      .rd_row(rd_row), .rd_data(rd_data), .in_vec(in_vec), .out_vec(out_vec)
   );

   // Row layout: {mask[3:0], care[2:0], pol[2:0]}; A=bit2, B=bit1, C=bit0.
   function automatic logic [RW-1:0] mk_row(input logic [3:0] mask, input logic [2:0] care,
                                             input logic [2:0] pol);
      return {mask, care, pol};
   endfunction

   function automatic logic [NO-1:0] ref_eq(input logic [2:0] x);
      logic a, b, c;
      a = x[2]; b = x[1]; c = x[0];
      return {(~b & c) | a, (~b & ~c) | (a & b), (a & ~c) | (a & b), a | (~b & ~c)};
   endfunction

   function automatic logic [NO-1:0] model(input logic [2:0] x);
      logic [NO-1:0] res;
      res = '0;
      for (int p = 0; p < NT; p++) begin
         if (((x ^ shadow[p][2:0]) & shadow[p][5:3]) == 3'b000) res |= shadow[p][9:6];
      end
      return res;
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_row(input logic [AW-1:0] row, input logic [RW-1:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_row = row; cfg_data = data;
      @(negedge clk);
      cfg_we = 1'b0;
      if (row < NT) shadow[row] = data;
   endtask

   task automatic all_inputs_vs_model(input string req);
      for (int i = 0; i < 8; i++) begin
         in_vec = 3'(i);
         #1;
         check(req, 16'(out_vec), 16'(model(3'(i))));
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int p = 0; p < NT; p++) shadow[p] = '0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         in_vec = 3'(i); #1;
         check("R1 out during reset", 16'(out_vec), 16'h0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         in_vec = 3'(i); #1;
         check("R1 out after reset", 16'(out_vec), 16'h0);
      end
      for (int p = 0; p < NT; p++) begin
         rd_row = 3'(p); #1;
         check("R1 readback after reset", 16'(rd_data), 16'h0);
      end

      // Reference personality: AB, B'C, AC', B'C', A
      write_row(3'd0, mk_row(4'b0110, 3'b110, 3'b110));
      write_row(3'd1, mk_row(4'b1000, 3'b011, 3'b001));
      write_row(3'd2, mk_row(4'b0010, 3'b101, 3'b100));
      write_row(3'd3, mk_row(4'b0101, 3'b011, 3'b000));
      write_row(3'd4, mk_row(4'b1001, 3'b100, 3'b100));
      for (int p = 0; p < NT; p++) begin
         rd_row = 3'(p); #1;
         check("R2 readback of written row", 16'(rd_data), 16'(shadow[p]));
      end
      for (int i = 0; i < 8; i++) begin
         in_vec = 3'(i); #1;
         check("R3 R5 reference equations", 16'(out_vec), 16'(ref_eq(3'(i))));
      end
      // A=1,B=1,C=0: term AB feeds F1 and F2, term A feeds F0 and F3
      in_vec = 3'b110; #1;
      check("R6 shared terms", 16'(out_vec), 16'hF);
      // A=0,B=0,C=0: only B'C' is true, it feeds F0 and F2
      in_vec = 3'b000; #1;
      check("R6 single term drives two outputs", 16'(out_vec), 16'h5);
      // A=0,B=1,C=1: no term true
      in_vec = 3'b011; #1;
      check("R3 no literal match gives zero", 16'(out_vec), 16'h0);

      // R5: strip every connection to F3
      write_row(3'd1, mk_row(4'b0000, 3'b011, 3'b001));
      write_row(3'd4, mk_row(4'b0001, 3'b100, 3'b100));
      for (int i = 0; i < 8; i++) begin
         in_vec = 3'(i); #1;
         check("R5 unconnected output is 0", 16'(out_vec[3]), 16'h0);
      end

      // R4 and R2 timing: all-don't-care term routed to F3
      in_vec = 3'b011;
      @(negedge clk);
      cfg_we = 1'b1; cfg_row = 3'd2; cfg_data = mk_row(4'b1000, 3'b000, 3'b101);
      #1;
      check("R2 old row holds before edge", 16'(out_vec[3]), 16'h0);
      @(negedge clk);
      cfg_we = 1'b0;
      shadow[2] = mk_row(4'b1000, 3'b000, 3'b101);
      #1;
      check("R2 new row after edge", 16'(out_vec[3]), 16'h1);
      for (int i = 0; i < 8; i++) begin
         in_vec = 3'(i); #1;
         check("R4 empty term is true", 16'(out_vec[3]), 16'h1);
      end

      // R7: out-of-range writes
      write_row(3'd6, mk_row(4'b1111, 3'b000, 3'b000));
      write_row(3'd7, mk_row(4'b1111, 3'b000, 3'b000));
      all_inputs_vs_model("R7 out-of-range write ignored");
      rd_row = 3'd6; #1;
      check("R7 out-of-range readback is 0", 16'(rd_data), 16'h0);
      for (int p = 0; p < NT; p++) begin
         rd_row = 3'(p); #1;
         check("R7 rows unchanged", 16'(rd_data), 16'(shadow[p]));
      end

      // Random personalities and inputs
      for (int k = 0; k < 60; k++) begin
         write_row(3'($urandom_range(7, 0)), RW'($urandom));
         for (int j = 0; j < 4; j++) begin
            logic [2:0] x;
            x = 3'($urandom_range(7, 0));
            in_vec = x; #1;
            check("R3 R8 random evaluation", 16'(out_vec), 16'(model(x)));
         end
      end
      all_inputs_vs_model("R3 final sweep");
      finish_run();
   end

endmodule